// File: doc/BRIEF.md
# Alternating-Reload PWM Timer

This block is a pair of 16-bit down-counters. The first counter produces a PWM waveform with no software involvement. Each time it underflows it loads its next start value from one of two reload registers. It takes them in turn, A first and then B. When toggling is enabled, the output pin changes level at every underflow, so register A sets the length of the high phase and register B sets the length of the low phase. The second counter is a plain event or system timer. Software loads it, it counts down, and it raises an interrupt when it wraps.

Each counter has its own clock-source selector:

- no clock (the counter is stopped),
- a prescaled system clock,
- rising edges of the external event input,
- system cycles while the external event input is high (pulse accumulate),
- rising edges of a slow reference clock.

The external and slow inputs are asynchronous. Each passes through a two-flop synchronizer and an edge detector before it reaches the counters. Configuration uses a plain, single-cycle register write port with no back-pressure. The block has no streaming data path, so it has no valid/ready handshake. Reloads and underflows set three pending flags, and each flag is gated by its own enable onto an interrupt line.

Top module: `altpwm_timer`

## Requirements
- R1: After reset, `pwm_out`, all three pending flags and all three interrupt lines are 0. The reload sequence points at A, and the prescaler divisor is 0.
- R2: When its source is running, counter 1 starts from the value last written to it and decrements by one per tick. The tick that finds it at 0 is an underflow. So the first underflow happens on the (value+1)-th tick.
- R3: Underflows load counter 1 alternately from reload A and reload B, starting with A. With toggling enabled, the high phase lasts A+1 ticks and the low phase lasts B+1 ticks.
- R4: While counter 1's source is "none" (code 0), the sequence is reset, so the first reload after a restart comes from A.
- R5: Writing the control register forces `pwm_out` to control bit 1. Control bit 0 enables toggling on underflow. When toggling is off, `pwm_out` holds its level through underflows.
- R6: A reload from A sets `pend_a` and a reload from B sets `pend_b`. `irq_a` = `pend_a` AND control bit 2, and `irq_b` = `pend_b` AND control bit 3.
- R7: Writing 1 to bit 0, 1 or 2 at address 7 clears `pend_a`, `pend_b` or `pend_c2` respectively. A flag set by hardware in the same cycle stays set.
- R8: Source code 2 makes each rising edge of `ext_evt` produce exactly one tick, however long the input stays high. The edge is seen after the two-flop synchronizer.
- R9: Source code 3 produces one tick for every system cycle in which the synchronized `ext_evt` is high.
- R10: Source code 4 produces one tick per rising edge of `slow_clk`. Codes 5 to 7 produce no tick.
- R11: Source code 1 ticks once every N+1 cycles, where N is the 8-bit divisor at address 6. Writing the divisor restarts the prescaler phase at 0.
- R12: Counter 2 is loaded through address 3 and decrements per tick of its own source. The underflow on its (value+1)-th tick sets `pend_c2`, and the counter wraps to 0xFFFF. `irq_c2` = `pend_c2` AND control bit 4.
- R13: The address map is as follows.
  - 0: counter 1 value
  - 1: reload A
  - 2: reload B
  - 3: counter 2 value
  - 4: source select, bits [2:0] for counter 1 and bits [6:4] for counter 2
  - 5: control
  - 6: prescaler divisor, bits [7:0]
  - 7: pending-flag clear
  
  A write to address 0 or 3 takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| ext_evt | input | 1 | Asynchronous external event input |
| slow_clk | input | 1 | Asynchronous slow reference clock |
| pwm_out | output | 1 | PWM waveform |
| pend_a | output | 1 | Reload-from-A pending flag |
| pend_b | output | 1 | Reload-from-B pending flag |
| pend_c2 | output | 1 | Counter 2 underflow pending flag |
| irq_a | output | 1 | Interrupt for reload A |
| irq_b | output | 1 | Interrupt for reload B |
| irq_c2 | output | 1 | Interrupt for counter 2 underflow |

## Verification
Two situations are hard to reach from the ports.

The first is the sequence restart. To show it, counter 1 must be stopped exactly when its next reload would come from B. The stimulus waits for `pend_a` to rise and then selects "none" straight away. After clearing the flags, it preloads the counter with 1 and restarts it. Only `pend_a` may rise after that.

The second is the collision between a software clear and a hardware set. The restart scenario handles it too. With the prescaler divisor at 0, the underflow edge can be predicted exactly. The clear is timed to land on that same edge, so `pend_a` must still read 1 afterwards.

// File: rtl/altpwm_pkg.sv
package altpwm_pkg;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_PRESC = 3'd1,
    SRC_EVENT = 3'd2,
    SRC_ACCUM = 3'd3,
    SRC_SLOW  = 3'd4
  } clksrc_e;

  typedef enum logic [2:0] {
    ADR_CNT1   = 3'd0,
    ADR_RLDA   = 3'd1,
    ADR_RLDB   = 3'd2,
    ADR_CNT2   = 3'd3,
    ADR_SRCSEL = 3'd4,
    ADR_CTRL   = 3'd5,
    ADR_PSC    = 3'd6,
    ADR_PCLR   = 3'd7
  } regaddr_e;

  // control register bit positions
  localparam int CTL_TOG    = 0;
  localparam int CTL_INIT   = 1;
  localparam int CTL_IEN_A  = 2;
  localparam int CTL_IEN_B  = 3;
  localparam int CTL_IEN_C2 = 4;
  localparam int CTL_W      = 5;

  // map a source code to a count enable for this cycle
  function automatic logic pick_tick(logic [2:0] sel, logic presc, logic ev_rise,
                                     logic ev_lvl, logic slow_rise);
    logic t;
    case (sel)
      SRC_PRESC: t = presc;
      SRC_EVENT: t = ev_rise;
      SRC_ACCUM: t = ev_lvl;
      SRC_SLOW:  t = slow_rise;
      default:   t = 1'b0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/apt_edge_sync.sv
module apt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_i};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~last_q;

  // R8
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/apt_prescaler.sv
module apt_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div_i,
  input  logic         restart_i,
  output logic         tick_o
);
  logic [W-1:0] pcnt_q;

  assign tick_o = (pcnt_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt_q <= '0;
    else if (restart_i)      pcnt_q <= '0;
    else if (tick_o)         pcnt_q <= '0;
    else                     pcnt_q <= pcnt_q + 1'b1;
  end

  // R11
  presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !restart_i) |=> pcnt_q == '0);
  // R11
  presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_i |=> pcnt_q <= $past(div_i) || pcnt_q == '0);
endmodule

// File: rtl/apt_pwm_core.sv
module apt_pwm_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         stopped_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] rld_a_i,
  input  logic [W-1:0] rld_b_i,
  input  logic         tog_en_i,
  input  logic         lvl_wr_i,
  input  logic         lvl_i,
  output logic         out_o,
  output logic         rel_a_o,
  output logic         rel_b_o
);
  logic [W-1:0] cnt_q;
  logic         use_b_q;
  logic         uf;

  assign uf      = tick_i & (cnt_q == '0) & ~load_i;
  assign rel_a_o = uf & ~use_b_q;
  assign rel_b_o = uf &  use_b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      use_b_q <= 1'b0;
      out_o   <= 1'b0;
    end else begin
      if (load_i)      cnt_q <= load_val_i;
      else if (uf)     cnt_q <= use_b_q ? rld_b_i : rld_a_i;
      else if (tick_i) cnt_q <= cnt_q - 1'b1;

      if (stopped_i)   use_b_q <= 1'b0;
      else if (uf)     use_b_q <= ~use_b_q;

      if (lvl_wr_i)            out_o <= lvl_i;
      else if (uf && tog_en_i) out_o <= ~out_o;
    end
  end

  // R2
  pwm_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_q != '0 && !load_i) |=> cnt_q == W'($past(cnt_q) - 1'b1));
  // R3
  pwm_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> cnt_q == ($past(use_b_q) ? $past(rld_b_i) : $past(rld_a_i)));
  // R4
  pwm_restart_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped_i |=> !use_b_q);
  // R5
  pwm_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && tog_en_i && !lvl_wr_i) |=> out_o != $past(out_o));
  // R5
  pwm_hold_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tog_en_i && !lvl_wr_i) |=> $stable(out_o));
  // R2
  pwm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/apt_evt_counter.sv
module apt_evt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         uf_o
);
  logic [W-1:0] cnt_q;

  assign uf_o = tick_i & (cnt_q == '0) & ~load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q - 1'b1;
  end

  // R12
  evt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_o |=> cnt_q == '1);
  // R12
  evt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/altpwm_timer.sv
module altpwm_timer
  import altpwm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ext_evt,
  input  logic             slow_clk,
  output logic             pwm_out,
  output logic             pend_a,
  output logic             pend_b,
  output logic             pend_c2,
  output logic             irq_a,
  output logic             irq_b,
  output logic             irq_c2
);
  localparam int NSYNC = 2;   // index 0: external event, 1: slow clock

  logic [CNT_W-1:0] rld_a_q, rld_b_q;
  logic [2:0]       sel1_q, sel2_q;
  logic [CTL_W-1:0] ctl_q;
  logic [PSC_W-1:0] psc_q;

  logic wr_cnt1, wr_cnt2, wr_ctl, wr_psc, wr_clr;
  assign wr_cnt1 = wr_en && (wr_addr == ADR_CNT1);
  assign wr_cnt2 = wr_en && (wr_addr == ADR_CNT2);
  assign wr_ctl  = wr_en && (wr_addr == ADR_CTRL);
  assign wr_psc  = wr_en && (wr_addr == ADR_PSC);
  assign wr_clr  = wr_en && (wr_addr == ADR_PCLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_a_q <= '0;
      rld_b_q <= '0;
      sel1_q  <= SRC_NONE;
      sel2_q  <= SRC_NONE;
      ctl_q   <= '0;
      psc_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_RLDA:   rld_a_q <= wr_data;
        ADR_RLDB:   rld_b_q <= wr_data;
        ADR_SRCSEL: begin
          sel1_q <= wr_data[2:0];
          sel2_q <= wr_data[6:4];
        end
        ADR_CTRL:   ctl_q <= wr_data[CTL_W-1:0];
        ADR_PSC:    psc_q <= wr_data[PSC_W-1:0];
        default: ;
      endcase
    end
  end

  // input synchronizers
  logic [NSYNC-1:0] async_in, sync_lvl, sync_rise;
  assign async_in = {slow_clk, ext_evt};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    apt_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_i(async_in[g]),
      .level_o(sync_lvl[g]), .rise_o(sync_rise[g])
    );
  end

  logic presc_tick;
  apt_prescaler #(.W(PSC_W)) presc_i (
    .clk(clk), .rst_n(rst_n), .div_i(psc_q), .restart_i(wr_psc), .tick_o(presc_tick)
  );

  logic tick1, tick2;
  assign tick1 = pick_tick(sel1_q, presc_tick, sync_rise[0], sync_lvl[0], sync_rise[1]);
  assign tick2 = pick_tick(sel2_q, presc_tick, sync_rise[0], sync_lvl[0], sync_rise[1]);

  logic rel_a, rel_b, uf2;
  apt_pwm_core #(.W(CNT_W)) pwm_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick1), .stopped_i(sel1_q == SRC_NONE),
    .load_i(wr_cnt1), .load_val_i(wr_data), .rld_a_i(rld_a_q), .rld_b_i(rld_b_q),
    .tog_en_i(ctl_q[CTL_TOG]), .lvl_wr_i(wr_ctl), .lvl_i(wr_data[CTL_INIT]),
    .out_o(pwm_out), .rel_a_o(rel_a), .rel_b_o(rel_b)
  );

  apt_evt_counter #(.W(CNT_W)) evt_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick2), .load_i(wr_cnt2),
    .load_val_i(wr_data), .uf_o(uf2)
  );

  // pending flags: hardware set beats software clear
  logic [2:0] pend_q, pend_set, pend_clr;
  assign pend_set = {uf2, rel_b, rel_a};
  assign pend_clr = wr_clr ? wr_data[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_set | (pend_q & ~pend_clr);
  end

  assign pend_a  = pend_q[0];
  assign pend_b  = pend_q[1];
  assign pend_c2 = pend_q[2];
  assign irq_a   = pend_q[0] & ctl_q[CTL_IEN_A];
  assign irq_b   = pend_q[1] & ctl_q[CTL_IEN_B];
  assign irq_c2  = pend_q[2] & ctl_q[CTL_IEN_C2];

  // R7
  pend_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_a |=> pend_a);
  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && wr_data[1] && !rel_b) |=> !pend_b);
  // R6
  one_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rel_a && rel_b));
  // R4
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel1_q == SRC_NONE) |-> !rel_a && !rel_b);
endmodule

// File: tb/altpwm_timer_tb_top.sv
module altpwm_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic ext_evt = 1'b0;
  logic slow_clk = 1'b0;
  logic pwm_out, pend_a, pend_b, pend_c2, irq_a, irq_b, irq_c2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  altpwm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_evt(ext_evt), .slow_clk(slow_clk), .pwm_out(pwm_out), .pend_a(pend_a),
    .pend_b(pend_b), .pend_c2(pend_c2), .irq_a(irq_a), .irq_b(irq_b), .irq_c2(irq_c2)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge; returns at the following negedge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input bit on_slow, input int hi, input int gap);
    if (on_slow) slow_clk = 1'b1; else ext_evt = 1'b1;
    repeat (hi) @(negedge clk);
    if (on_slow) slow_clk = 1'b0; else ext_evt = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(pwm_out == 0, "R1 pwm_out", pwm_out, 0);
    chk({pend_a, pend_b, pend_c2} == 0, "R1 pending", {pend_a, pend_b, pend_c2}, 0);
    chk({irq_a, irq_b, irq_c2} == 0, "R1 irq", {irq_a, irq_b, irq_c2}, 0);
  endtask

  task automatic t_first_underflow();
    wr(3'd6, 16'd0);        // divisor 0: tick every cycle
    wr(3'd1, 16'd5);        // reload A
    wr(3'd2, 16'd2);        // reload B
    wr(3'd0, 16'd2);        // counter 1 start value
    wr(3'd5, 16'h0005);     // toggle, init low, irq A enabled
    wr(3'd4, 16'h0001);     // counter 1 on prescaler
    repeat (2) @(negedge clk);
    chk(pwm_out == 0, "R2 no underflow before value+1 ticks", pwm_out, 0);
    chk(pend_a == 0, "R2 pend_a early", pend_a, 0);
    @(negedge clk);
    chk(pwm_out == 1, "R2 underflow on tick value+1", pwm_out, 1);
    chk(pend_a == 1 && pend_b == 0, "R3 first reload from A (R13 map)", {pend_a, pend_b}, 2'b10);
    chk(irq_a == 1, "R6 irq_a follows enable", irq_a, 1);
  endtask

  task automatic t_alternate();
    int n;
    n = 0;
    while (pwm_out == 1 && n < 100) begin @(negedge clk); n++; end
    chk(pend_b == 1, "R6 pend_b on B reload", pend_b, 1);
    chk(irq_b == 0, "R6 irq_b masked", irq_b, 0);
    n = 0;
    while (pwm_out == 0 && n < 100) begin @(negedge clk); n++; end
    n = 0;
    while (pwm_out == 1 && n < 100) begin @(negedge clk); n++; end
    chk(n == 6, "R3 high phase A+1", n, 6);
    n = 0;
    while (pwm_out == 0 && n < 100) begin @(negedge clk); n++; end
    chk(n == 3, "R3 low phase B+1", n, 3);
  endtask

  task automatic t_stop_restart();
    int n;
    wr(3'd7, 16'h0003);
    n = 0;
    while (pend_a == 0 && n < 100) begin @(negedge clk); n++; end
    wr(3'd4, 16'h0000);     // stop right after an A reload: next would be B
    wr(3'd7, 16'h0003);
    chk({pend_a, pend_b} == 0, "R7 write-one clear", {pend_a, pend_b}, 0);
    repeat (12) @(negedge clk);
    chk({pend_a, pend_b} == 0, "R4 stopped counter idle", {pend_a, pend_b}, 0);
    wr(3'd0, 16'd1);
    wr(3'd4, 16'h0001);
    @(negedge clk);
    wr(3'd7, 16'h0001);     // clear of A lands on the underflow edge
    chk(pend_a == 1, "R7 hardware set wins over clear", pend_a, 1);
    chk(pend_b == 0, "R4 restart reloads from A", pend_b, 0);
  endtask

  task automatic t_level();
    wr(3'd4, 16'h0000);
    wr(3'd5, 16'h0002);     // init high, toggle off
    chk(pwm_out == 1, "R5 init level written", pwm_out, 1);
    wr(3'd7, 16'h0003);
    wr(3'd0, 16'd0);
    wr(3'd4, 16'h0001);
    repeat (20) @(negedge clk);
    chk(pwm_out == 1, "R5 no toggle when disabled", pwm_out, 1);
    chk(pend_a == 1, "R5 underflows did occur", pend_a, 1);
    wr(3'd4, 16'h0000);
    wr(3'd5, 16'h0010);     // init low, irq C2 enabled
    chk(pwm_out == 0, "R5 init low written", pwm_out, 0);
  endtask

  task automatic t_event();
    wr(3'd7, 16'h0004);
    wr(3'd3, 16'd2);
    wr(3'd4, 16'h0020);
    pulse(1'b0, 5, 6);
    pulse(1'b0, 5, 6);
    chk(pend_c2 == 0, "R8 one tick per long pulse", pend_c2, 0);
    pulse(1'b0, 5, 6);
    chk(pend_c2 == 1, "R12 underflow on third event", pend_c2, 1);
    chk(irq_c2 == 1, "R12 irq_c2 enabled", irq_c2, 1);
  endtask

  task automatic t_accum();
    wr(3'd4, 16'h0000);
    wr(3'd7, 16'h0004);
    wr(3'd3, 16'd4);
    wr(3'd4, 16'h0030);
    pulse(1'b0, 4, 6);
    chk(pend_c2 == 0, "R9 four high cycles count four", pend_c2, 0);
    pulse(1'b0, 1, 6);
    chk(pend_c2 == 1, "R9 fifth high cycle underflows", pend_c2, 1);
  endtask

  task automatic t_slow();
    wr(3'd4, 16'h0000);
    wr(3'd7, 16'h0004);
    wr(3'd3, 16'd1);
    wr(3'd4, 16'h0040);
    pulse(1'b1, 3, 5);
    chk(pend_c2 == 0, "R10 one slow edge", pend_c2, 0);
    pulse(1'b1, 3, 5);
    chk(pend_c2 == 1, "R10 second slow edge underflows", pend_c2, 1);
    wr(3'd4, 16'h0050);     // code 5 selects nothing
    wr(3'd7, 16'h0004);
    wr(3'd3, 16'd0);
    pulse(1'b1, 3, 5);
    pulse(1'b0, 3, 5);
    chk(pend_c2 == 0, "R10 unused code gives no tick", pend_c2, 0);
  endtask

  task automatic t_presc();
    wr(3'd4, 16'h0000);
    wr(3'd7, 16'h0004);
    wr(3'd3, 16'd1);
    wr(3'd6, 16'd3);
    wr(3'd4, 16'h0010);
    repeat (6) @(negedge clk);
    chk(pend_c2 == 0, "R11 before second prescaled tick", pend_c2, 0);
    @(negedge clk);
    chk(pend_c2 == 1, "R11 tick every N+1 cycles", pend_c2, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_underflow();
    t_alternate();
    t_stop_restart();
    t_level();
    t_event();
    t_accum();
    t_slow();
    t_presc();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule